// File: doc/BRIEF.md
# Shared Unit Lock Arbiter

The block decides which media engine owns each of two shared scaler/format-converter units. Four decode engines and two enhancement engines each drive a lock request. Decode engine n competes for unit n>>1 and enhancement engine n for unit n, so every unit has three candidates. A unit is granted to at most one engine at a time. Simultaneous requests are served in round-robin order, and a unit becomes free again when its owner drops its request.

Ahead of resetting an engine, software sets that engine's freeze bit through a small register port. While any enabled freeze bit on a unit is set, the unit's ownership is frozen. An owner keeps the unit even without a request, and a free unit accepts no grants. Two cycles later the engine raises an acknowledge bit. From then on, software may read the engine's usage bit and know that it will not change until the freeze bit is cleared. Decode engines can be barred from the shared units by a per-engine access mask.

Top module: `shared_lock_arbiter`

## Requirements
- R1: After a synchronous reset, all ownership outputs, freeze bits and acknowledge bits are 0, and read data is 0.
- R2: Decode engine n competes only for unit n>>1 and enhancement engine n only for unit n. Each unit has at most one owner.
- R3: A free, unfrozen unit with an eligible request grants one cycle after the request is sampled. The owner keeps the unit while it requests. The unit frees one cycle after the owner's request drops. A new grant comes no earlier than the following cycle.
- R4: Within a unit the candidate slots are decode 2u, decode 2u+1 and enhancement u, in that order. A grant goes to the first requesting slot after the slot granted last, wrapping around. After reset the search starts at slot 0.
- R5: A decode engine whose access bit is 0 is never granted. Its acknowledge and usage bits read 0, and its freeze bit does not freeze the unit.
- R6: An owner whose freeze bit is set keeps the unit, even with its request low, until the freeze bit is cleared.
- R7: While any enabled freeze bit of a unit's candidates is set, that unit grants to nobody new, and requests from any of its candidates are ignored.
- R8: An engine's acknowledge bit rises two cycles after its freeze bit becomes 1 and falls one cycle after the freeze bit is cleared.
- R9: While an acknowledge bit is 1, the usage bits of that engine's unit do not change.
- R10: Writing 0 to a freeze bit that is already 0 changes no ownership and no status.
- R11: Register address = {engine slot[4:2], select[1:0]}, where slots 0-3 are decode engines 0-3. Decode select 0 is the control word with the freeze bit in bit 0. Select 1 is status, with usage in bit 0 and acknowledge in bit 1.
- R12: Slots 4-5 are enhancement engines 0-1. Select 0 holds freeze, select 1 acknowledge and select 2 usage, each in bit 0. Other addresses read 0 and ignore writes. Read data is registered and reflects the address one cycle earlier. A write with select 0 stores wdata bit 0 as the freeze bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_req_i | input | NUM_DEC | Lock requests, decode engines |
| dec_access_i | input | NUM_DEC | Per-decode-engine access enable |
| enh_req_i | input | NUM_UNIT | Lock requests, enhancement engines |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register address |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Registered read data |
| dec_own_o | output | NUM_DEC | Decode engine currently owns its unit |
| enh_own_o | output | NUM_UNIT | Enhancement engine currently owns its unit |

## Verification
Arbitration is driven with three patterns. A lone requester shows the grant and release latency. All three candidates requesting together, with owners stepping down in turn, separates true round-robin from fixed priority. Random request traffic mixed with random register writes and reads covers the remaining interleavings. Freeze tests set the bit on an owner that then drops its request, and on a non-owner while a neighbour asks for the unit. Together these show whether ownership is frozen or only the request path is gated. Register reads timed around each freeze edge pin down the acknowledge latency and the stability of usage.

// File: rtl/sla_pkg.sv
package sla_pkg;
  // register select field inside an engine's window
  typedef enum logic [1:0] {
    SEL_FREEZE = 2'd0,
    SEL_STAT_A = 2'd1,
    SEL_STAT_B = 2'd2,
    SEL_RSVD   = 2'd3
  } reg_sel_e;

  localparam int SEL_W = 2;
endpackage

// File: rtl/sla_ack_pipe.sv
module sla_ack_pipe (
  input  logic clk,
  input  logic rst,
  input  logic freeze_i,
  input  logic enable_i,
  output logic ack_o
);
  logic seen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_q <= 1'b0;
      ack_o  <= 1'b0;
    end else begin
      seen_q <= freeze_i & enable_i;
      ack_o  <= freeze_i & enable_i & seen_q;
    end
  end
endmodule

// File: rtl/sla_unit_arb.sv
module sla_unit_arb #(
  parameter  int CAND = 3,
  localparam int PW   = (CAND > 1) ? $clog2(CAND) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [CAND-1:0] req_i,
  input  logic            freeze_i,
  output logic [CAND-1:0] own_o
);
  logic [PW-1:0]   ptr_q;
  logic [PW-1:0]   pick_idx;
  logic            pick_vld;
  logic [CAND-1:0] pick_oh;

  // round-robin search: slots after ptr first, then wrap to ptr and below
  always_comb begin
    pick_vld = 1'b0;
    pick_idx = '0;
    pick_oh  = '0;
    for (int c = 0; c < CAND; c++) begin
      if (!pick_vld && req_i[c] && (PW'(c) > ptr_q)) begin
        pick_vld   = 1'b1;
        pick_idx   = PW'(c);
        pick_oh[c] = 1'b1;
      end
    end
    for (int c = 0; c < CAND; c++) begin
      if (!pick_vld && req_i[c] && (PW'(c) <= ptr_q)) begin
        pick_vld   = 1'b1;
        pick_idx   = PW'(c);
        pick_oh[c] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      own_o <= '0;
      ptr_q <= PW'(CAND - 1);
    end else if (!freeze_i) begin
      if (|own_o) begin
        if (!(|(own_o & req_i))) own_o <= '0;
      end else if (pick_vld) begin
        own_o <= pick_oh;
        ptr_q <= pick_idx;
      end
    end
  end
endmodule

// File: rtl/sla_regs.sv
module sla_regs
  import sla_pkg::*;
#(
  parameter  int NUM_DEC = 4,
  parameter  int NUM_ENH = 2,
  parameter  int DATA_W  = 32,
  localparam int NE      = NUM_DEC + NUM_ENH,
  localparam int ENG_AW  = (NE > 1) ? $clog2(NE) : 1,
  localparam int ADDR_W  = ENG_AW + SEL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [NE-1:0]     usage_i,
  input  logic [NE-1:0]     ack_i,
  output logic [NE-1:0]     freeze_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [ENG_AW-1:0] slot;
  reg_sel_e          sel;
  logic [DATA_W-1:0] rd_mux;
  logic              unused_wdata_hi;

  assign slot            = addr_i[ADDR_W-1:SEL_W];
  assign sel             = reg_sel_e'(addr_i[SEL_W-1:0]);
  assign unused_wdata_hi = ^wdata_i[DATA_W-1:1];

  always_ff @(posedge clk) begin
    if (rst) begin
      freeze_o <= '0;
    end else if (wr_i && sel == SEL_FREEZE) begin
      for (int e = 0; e < NE; e++)
        if (slot == ENG_AW'(e)) freeze_o[e] <= wdata_i[0];
    end
  end

  always_comb begin
    rd_mux = '0;
    for (int e = 0; e < NE; e++) begin
      if (slot == ENG_AW'(e)) begin
        if (e < NUM_DEC) begin
          case (sel)
            SEL_FREEZE: rd_mux[0] = freeze_o[e];
            SEL_STAT_A: begin
              rd_mux[0] = usage_i[e];
              rd_mux[1] = ack_i[e];
            end
            default: rd_mux = '0;
          endcase
        end else begin
          case (sel)
            SEL_FREEZE: rd_mux[0] = freeze_o[e];
            SEL_STAT_A: rd_mux[0] = ack_i[e];
            SEL_STAT_B: rd_mux[0] = usage_i[e];
            default:    rd_mux    = '0;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_o <= '0;
    else     rdata_o <= rd_mux;
  end
endmodule

// File: rtl/shared_lock_arbiter.sv
module shared_lock_arbiter
  import sla_pkg::*;
#(
  parameter  int NUM_UNIT     = 2,
  parameter  int DEC_PER_UNIT = 2,
  parameter  int DATA_W       = 32,
  localparam int NUM_DEC      = NUM_UNIT * DEC_PER_UNIT,
  localparam int NE           = NUM_DEC + NUM_UNIT,
  localparam int ENG_AW       = (NE > 1) ? $clog2(NE) : 1,
  localparam int ADDR_W       = ENG_AW + SEL_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_DEC-1:0] dec_req_i,
  input  logic [NUM_DEC-1:0] dec_access_i,
  input  logic [NUM_UNIT-1:0] enh_req_i,
  input  logic               reg_wr_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [DATA_W-1:0]  reg_wdata_i,
  output logic [DATA_W-1:0]  reg_rdata_o,
  output logic [NUM_DEC-1:0] dec_own_o,
  output logic [NUM_UNIT-1:0] enh_own_o
);
  localparam int CAND = DEC_PER_UNIT + 1;

  logic [NE-1:0] acc_all;
  logic [NE-1:0] req_all;
  logic [NE-1:0] force_q;
  logic [NE-1:0] force_eff;
  logic [NE-1:0] ack_q;
  logic [NE-1:0] usage_all;

  assign acc_all   = {{NUM_UNIT{1'b1}}, dec_access_i};
  assign req_all   = {enh_req_i, dec_req_i} & acc_all;
  assign force_eff = force_q & acc_all;
  assign usage_all = {enh_own_o, dec_own_o};

  for (genvar u = 0; u < NUM_UNIT; u++) begin : g_unit
    logic [CAND-1:0] cand_req;
    logic [CAND-1:0] cand_own;
    logic            unit_frz;

    assign cand_req = {req_all[NUM_DEC+u], req_all[u*DEC_PER_UNIT +: DEC_PER_UNIT]};
    assign unit_frz = force_eff[NUM_DEC+u] |
                      (|force_eff[u*DEC_PER_UNIT +: DEC_PER_UNIT]);

    sla_unit_arb #(.CAND(CAND)) u_arb (
      .clk      (clk),
      .rst      (rst),
      .req_i    (cand_req),
      .freeze_i (unit_frz),
      .own_o    (cand_own)
    );

    assign dec_own_o[u*DEC_PER_UNIT +: DEC_PER_UNIT] = cand_own[DEC_PER_UNIT-1:0];
    assign enh_own_o[u]                              = cand_own[DEC_PER_UNIT];
  end

  for (genvar e = 0; e < NE; e++) begin : g_ack
    sla_ack_pipe u_ack (
      .clk      (clk),
      .rst      (rst),
      .freeze_i (force_q[e]),
      .enable_i (acc_all[e]),
      .ack_o    (ack_q[e])
    );
  end

  sla_regs #(
    .NUM_DEC (NUM_DEC),
    .NUM_ENH (NUM_UNIT),
    .DATA_W  (DATA_W)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_i     (reg_wr_i),
    .addr_i   (reg_addr_i),
    .wdata_i  (reg_wdata_i),
    .usage_i  (usage_all),
    .ack_i    (ack_q),
    .freeze_o (force_q),
    .rdata_o  (reg_rdata_o)
  );
endmodule

// File: rtl/shared_lock_arbiter_chk.sv
module shared_lock_arbiter_chk #(
  parameter  int NUM_UNIT     = 2,
  parameter  int DEC_PER_UNIT = 2,
  localparam int NUM_DEC      = NUM_UNIT * DEC_PER_UNIT,
  localparam int NE           = NUM_DEC + NUM_UNIT,
  localparam int CAND         = DEC_PER_UNIT + 1
) (
  input logic          clk,
  input logic          rst,
  input logic [NE-1:0] req_all,
  input logic [NE-1:0] acc_all,
  input logic [NE-1:0] force_q,
  input logic [NE-1:0] ack_q,
  input logic [NE-1:0] usage_all
);
  logic [NUM_UNIT-1:0][CAND-1:0] uvec;
  logic [NUM_UNIT-1:0]           ufrz;
  logic [NE-1:0]                 fe;

  assign fe = force_q & acc_all;

  for (genvar u = 0; u < NUM_UNIT; u++) begin : g_u
    assign uvec[u] = {usage_all[NUM_DEC+u], usage_all[u*DEC_PER_UNIT +: DEC_PER_UNIT]};
    assign ufrz[u] = fe[NUM_DEC+u] | (|fe[u*DEC_PER_UNIT +: DEC_PER_UNIT]);

    AST_ONE_OWNER: assert property (@(posedge clk) disable iff (rst)
      $onehot0(uvec[u])); // R2

    AST_FROZEN_NO_GRANT: assert property (@(posedge clk) disable iff (rst)
      ($past(ufrz[u]) && !(|$past(uvec[u]))) |-> !(|uvec[u])); // R7
  end

  for (genvar e = 0; e < NE; e++) begin : g_e
    localparam int U = (e < NUM_DEC) ? (e / DEC_PER_UNIT) : (e - NUM_DEC);

    AST_GRANT_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
      $rose(usage_all[e]) |-> $past(req_all[e])); // R3

    AST_QUIET_NO_ACCESS: assert property (@(posedge clk) disable iff (rst)
      $past(!acc_all[e]) |-> !ack_q[e]); // R5

    AST_ACK_NOT_EARLY: assert property (@(posedge clk) disable iff (rst)
      $rose(fe[e]) |=> !ack_q[e]); // R8

    AST_ACK_RISES: assert property (@(posedge clk) disable iff (rst)
      (fe[e] && $past(fe[e]) && $past(fe[e], 2)) |=> ack_q[e]); // R8

    AST_ACK_FALLS: assert property (@(posedge clk) disable iff (rst)
      $fell(fe[e]) |=> !ack_q[e]); // R8

    AST_USAGE_STABLE: assert property (@(posedge clk) disable iff (rst)
      ack_q[e] |-> $stable(uvec[U])); // R9

    AST_HOLDER_KEEPS: assert property (@(posedge clk) disable iff (rst)
      ($past(fe[e]) && $past(usage_all[e])) |-> usage_all[e]); // R6
  end
endmodule

bind shared_lock_arbiter shared_lock_arbiter_chk #(
  .NUM_UNIT     (NUM_UNIT),
  .DEC_PER_UNIT (DEC_PER_UNIT)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_all   (req_all),
  .acc_all   (acc_all),
  .force_q   (force_q),
  .ack_q     (ack_q),
  .usage_all (usage_all)
);

// File: tb/tb_shared_lock_arbiter.sv
`timescale 1ns/1ps
module tb_shared_lock_arbiter;
  localparam int NU = 2, DPU = 2, ND = 4, NE = 6, CAND = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  dec_req = '0, dec_acc = 4'b0111;
  logic [1:0]  enh_req = '0;
  logic        wr = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  dec_own;
  logic [1:0]  enh_own;

  int checks = 0, fails = 0;
  string tag = "R1";

  int own_m [NU];
  int last_m[NU];
  bit frc[NE], seen[NE], ackm[NE];
  logic [31:0] exp_rd;

  always #2 clk = ~clk;

  shared_lock_arbiter dut (
    .clk(clk), .rst(rst), .dec_req_i(dec_req), .dec_access_i(dec_acc),
    .enh_req_i(enh_req), .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .dec_own_o(dec_own), .enh_own_o(enh_own));

  function automatic int eng_of(int u, int s);
    return (s < DPU) ? u*DPU + s : ND + u;
  endfunction
  function automatic bit accf(int e);
    return (e < ND) ? dec_acc[e] : 1'b1;
  endfunction
  function automatic bit rqf(int e);
    return (e < ND) ? dec_req[e] : enh_req[e-ND];
  endfunction
  function automatic bit usef(int e);
    int u, s;
    u = (e < ND) ? e / DPU : e - ND;
    s = (e < ND) ? e % DPU : DPU;
    return own_m[u] == s;
  endfunction

  task automatic chk(string t, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", t, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int u = 0; u < NU; u++) begin own_m[u] = -1; last_m[u] = CAND-1; end
    for (int e = 0; e < NE; e++) begin frc[e] = 0; seen[e] = 0; ackm[e] = 0; end
    exp_rd = '0;
  endtask

  task automatic model_step();
    int slot, sel;
    logic [31:0] rd;
    bit nack[NE], nseen[NE];
    slot = int'(addr[4:2]);
    sel  = int'(addr[1:0]);
    rd = '0;
    if (slot < ND) begin
      if (sel == 0) rd[0] = frc[slot];
      if (sel == 1) begin rd[0] = usef(slot); rd[1] = ackm[slot]; end
    end else if (slot < NE) begin
      if (sel == 0) rd[0] = frc[slot];
      if (sel == 1) rd[0] = ackm[slot];
      if (sel == 2) rd[0] = usef(slot);
    end
    for (int e = 0; e < NE; e++) begin
      nack[e]  = frc[e] && accf(e) && seen[e];
      nseen[e] = frc[e] && accf(e);
    end
    for (int u = 0; u < NU; u++) begin
      bit frz;
      frz = 0;
      for (int s = 0; s < CAND; s++) if (frc[eng_of(u,s)] && accf(eng_of(u,s))) frz = 1;
      if (!frz) begin
        if (own_m[u] >= 0) begin
          if (!(rqf(eng_of(u, own_m[u])) && accf(eng_of(u, own_m[u])))) own_m[u] = -1;
        end else begin
          for (int i = 1; i <= CAND; i++) begin
            int s;
            s = (last_m[u] + i) % CAND;
            if (own_m[u] < 0 && rqf(eng_of(u,s)) && accf(eng_of(u,s))) begin
              own_m[u] = s; last_m[u] = s;
            end
          end
        end
      end
    end
    for (int e = 0; e < NE; e++) begin ackm[e] = nack[e]; seen[e] = nseen[e]; end
    if (wr && sel == 0 && slot < NE) frc[slot] = wdata[0];
    exp_rd = rd;
  endtask

  task automatic tick();
    logic [5:0] eg;
    @(posedge clk);
    model_step();
    @(negedge clk);
    for (int e = 0; e < NE; e++) eg[e] = usef(e);
    chk({tag, " grants"}, {26'd0, enh_own, dec_own}, {26'd0, eg});
    chk({tag, " rdata"}, rdata, exp_rd);
  endtask

  task automatic wreg(int slot, int sel, bit v);
    addr = 5'(slot*4 + sel); wdata = {31'd0, v}; wr = 1'b1;
    tick();
    wr = 1'b0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R1 actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : stim
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    model_reset();
    // R1: reset state
    chk("R1 reset own", {26'd0, enh_own, dec_own}, 32'd0);
    chk("R1 reset rdata", rdata, 32'd0);

    // R3 / R2: single requester
    tag = "R3";
    dec_req[1] = 1'b1; tick();
    chk("R3 grant latency", {28'd0, dec_own}, 32'h2);
    dec_req[0] = 1'b1; tick();
    chk("R2 single owner", {28'd0, dec_own}, 32'h2);
    dec_req[1] = 1'b0; tick();
    chk("R3 release", {28'd0, dec_own}, 32'h0);
    tick();
    chk("R3 regrant", {28'd0, dec_own}, 32'h1);
    dec_req = '0; tick(); tick();

    // R4: round robin on unit 0 (last granted slot 0)
    tag = "R4";
    dec_req[1:0] = 2'b11; enh_req[0] = 1'b1; tick();
    chk("R4 first pick D1", {28'd0, dec_own}, 32'h2);
    dec_req[1] = 1'b0; tick(); dec_req[1] = 1'b1; tick();
    chk("R4 second pick E0", {30'd0, enh_own}, 32'h1);
    enh_req[0] = 1'b0; tick(); enh_req[0] = 1'b1; tick();
    chk("R4 third pick D0", {28'd0, dec_own}, 32'h1);
    dec_req = '0; enh_req = '0; tick(); tick();

    // R5: decode 3 has no access
    tag = "R5";
    dec_req[3] = 1'b1; tick(); tick();
    chk("R5 no grant", {28'd0, dec_own}, 32'h0);
    wreg(3, 0, 1'b1); addr = 5'(3*4 + 1); repeat (4) tick();
    chk("R5 status zero", rdata, 32'h0);
    enh_req[1] = 1'b1; tick(); tick();
    chk("R5 no freeze from masked", {30'd0, enh_own}, 32'h2);
    wreg(3, 0, 1'b0); dec_req[3] = 1'b0;

    // R6 / R8 / R12: freeze on owner E1
    tag = "R6";
    wreg(5, 0, 1'b1);
    addr = 5'(5*4 + 1);
    tick();
    chk("R8 ack not yet", rdata, 32'h0);
    tick(); tick();
    chk("R8 ack high", rdata, 32'h1);
    enh_req[1] = 1'b0; repeat (3) tick();
    chk("R6 owner kept", {30'd0, enh_own}, 32'h2);
    addr = 5'(5*4 + 2); tick(); tick();
    chk("R12 usage reads 1", rdata, 32'h1);
    tag = "R8";
    wreg(5, 0, 1'b0);
    addr = 5'(5*4 + 1); tick(); tick();
    chk("R8 ack low", rdata, 32'h0);
    chk("R6 release after unfreeze", {30'd0, enh_own}, 32'h0);

    // R7 / R11: freeze on non-owner blocks unit 0
    tag = "R7";
    wreg(1, 0, 1'b1);
    dec_req[0] = 1'b1; repeat (3) tick();
    chk("R7 no grant while frozen", {28'd0, dec_own}, 32'h0);
    addr = 5'(1*4 + 1); tick(); tick();
    chk("R11 status ack=1 usage=0", rdata, 32'h2);
    addr = 5'(1*4); tick(); tick();
    chk("R11 control freeze bit", rdata, 32'h1);
    wreg(1, 0, 1'b0); tick();
    chk("R7 grant after unfreeze", {28'd0, dec_own}, 32'h1);

    // R10: clearing a never-set freeze bit
    tag = "R10";
    wreg(0, 0, 1'b0); wreg(4, 0, 1'b0); tick();
    chk("R10 owner unchanged", {28'd0, dec_own}, 32'h1);
    dec_req = '0; tick(); tick();

    // R12: reserved and unmapped addresses
    tag = "R12";
    wreg(6, 0, 1'b1); addr = 5'(6*4); tick(); tick();
    chk("R12 unmapped reads 0", rdata, 32'h0);
    addr = 5'(4*4 + 3); tick(); tick();
    chk("R12 reserved reads 0", rdata, 32'h0);

    // R9: random traffic against the reference model
    tag = "R9";
    for (int n = 0; n < 3000; n++) begin
      dec_req = 4'($urandom);
      enh_req = 2'($urandom);
      addr    = 5'($urandom_range(0, 27));
      wr      = ($urandom_range(0, 9) == 0);
      wdata   = {31'd0, 1'($urandom_range(0, 2) == 0)};
      tick();
    end
    wr = 1'b0;

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule